// File: doc/BRIEF.md
# Buffered Page Program Engine

This block is the write path of a serial NOR flash controller. Software loads an opcode, a flash address and either a single data byte or a whole page of data into a small register bank. It then sets the go bit in the command register. The engine frames the transfer and sends it on a single-data-line SPI link: the opcode, then the address (three or four bytes, most significant first), then the data. The go bit reads back as set for the whole transfer and clears itself when chip select is released.

Two data modes are available, and a mode bit in the configuration register selects between them. In direct mode exactly one byte is sent. In page mode 128 bytes are sent from an internal page buffer. Software fills that buffer through a 32-bit data port, one little-endian word per write. The mode bit is a handshake: its read-back value follows the written request only once the engine has actually switched. Software can therefore poll for the change. Entering page mode rewinds the buffer fill pointer.

Top module: `snor_pp_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the command register reads 0 and the configuration register reads 0, which is direct mode.
- R2: A write to the command register (offset 0x00) with bit 4 set, made while idle, starts a transfer. Bit 4 reads 1 from the next cycle until chip select rises, and reads 0 afterwards.
- R3: A frame starts with the opcode byte (offset 0x20, bits 7:0) and is followed at once by the address, with no dummy cycles. When bit 4 of offset 0xcc is 0, the address is three bytes: 0x18, 0x14, 0x10, in that order. When that bit is 1, the byte at 0xc8 is sent first, followed by the same three. Every byte goes out most significant bit first.
- R4: In direct mode the frame carries exactly one data byte, taken from offset 0x1c. The total length is 8×(2+A) bits, where A is the address length in bytes.
- R5: In page mode the frame carries exactly 128 data bytes, sent in buffer byte order. Within each buffer word, bits 7:0 are the lowest byte and bits 31:24 the highest. Word n holds bytes 4n to 4n+3.
- R6: Bit 0 of the configuration register (offset 0x64) reads back the active mode. After a write, the read-back value changes one cycle later, never during a transfer.
- R7: Entering page mode resets the fill pointer to word 0. Each write to the page port (offset 0x98) in page mode stores one word and advances the pointer. The 33rd write wraps around to word 0.
- R8: Page-port writes made in direct mode change neither the buffer contents nor the fill pointer.
- R9: While a transfer is in progress, all register writes are ignored, including another go bit and a mode change.
- R10: The link uses SPI mode 0. The serial clock stays low while chip select is high. Each bit takes one low and one high clock cycle, and the data line holds steady while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| flash_sck | output | 1 | Serial clock to the flash |
| flash_cs_n | output | 1 | Active-low chip select |
| flash_mosi | output | 1 | Serial data to the flash |

## Verification
If the bit index or the header length goes wrong, the frame shows bytes out of place or a wrong bit count. This appears at the rising edge of chip select, within one frame time after the go bit. If the fill pointer is wrong, page bytes land in the wrong slots, so the page payload arrives rotated or stale. A wrong mode handshake shows in the configuration read-back one cycle after the write. It also shows as the wrong frame length on the next transfer. The bench rebuilds every expected frame from its own model of the registers and the page. It also checks the SPI mode 0 rules on every clock.

// File: rtl/snor_pp_pkg.sv
package snor_pp_pkg;

  // register byte offsets seen by software
  localparam logic [11:0] OFS_CMD   = 12'h000;
  localparam logic [11:0] OFS_ADR0  = 12'h010;
  localparam logic [11:0] OFS_ADR1  = 12'h014;
  localparam logic [11:0] OFS_ADR2  = 12'h018;
  localparam logic [11:0] OFS_WBYTE = 12'h01c;
  localparam logic [11:0] OFS_OPC   = 12'h020;
  localparam logic [11:0] OFS_CFG   = 12'h064;
  localparam logic [11:0] OFS_PAGE  = 12'h098;
  localparam logic [11:0] OFS_ADR3  = 12'h0c8;
  localparam logic [11:0] OFS_BUS   = 12'h0cc;

  localparam int GO_BIT    = 4;
  localparam int MODE_BIT  = 0;
  localparam int ADDR4_BIT = 4;

  typedef struct packed {
    logic [7:0]  opcode;
    logic [31:0] addr;
    logic [7:0]  wbyte;
    logic        addr4;
  } frame_cfg_t;

  // opcode plus address length in bytes
  function automatic logic [3:0] hdr_len(input logic addr4);
    return addr4 ? 4'd5 : 4'd4;
  endfunction

  // header byte at position pos (0 = opcode), address MSB first
  function automatic logic [7:0] hdr_byte(input frame_cfg_t c, input logic [2:0] pos);
    logic [2:0] na;
    logic [2:0] sh;
    na = c.addr4 ? 3'd4 : 3'd3;
    sh = na - pos;
    if (pos == 3'd0) return c.opcode;
    case (sh)
      3'd0:    return c.addr[7:0];
      3'd1:    return c.addr[15:8];
      3'd2:    return c.addr[23:16];
      default: return c.addr[31:24];
    endcase
  endfunction

  // total serial bits of a frame
  function automatic int unsigned frame_bit_count(input logic addr4, input logic paged,
                                                  input int unsigned page_bytes);
    return 8 * (int'(hdr_len(addr4)) + (paged ? page_bytes : 1));
  endfunction

endpackage

// File: rtl/snor_pp_regs.sv
module snor_pp_regs
  import snor_pp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wen,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        busy,
  input  logic        mode_ack,
  output logic [31:0] rdata,
  output logic        start,
  output frame_cfg_t  cfg,
  output logic        mode_req,
  output logic        page_wen,
  output logic [31:0] page_wdata
);

  // every write is dropped while a frame is on the wire
  logic wr_ok;
  assign wr_ok = bus_wen && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      mode_req <= 1'b0;
    end else if (wr_ok) begin
      case (bus_addr)
        OFS_OPC:   cfg.opcode      <= bus_wdata[7:0];
        OFS_ADR0:  cfg.addr[7:0]   <= bus_wdata[7:0];
        OFS_ADR1:  cfg.addr[15:8]  <= bus_wdata[7:0];
        OFS_ADR2:  cfg.addr[23:16] <= bus_wdata[7:0];
        OFS_ADR3:  cfg.addr[31:24] <= bus_wdata[7:0];
        OFS_WBYTE: cfg.wbyte       <= bus_wdata[7:0];
        OFS_BUS:   cfg.addr4       <= bus_wdata[ADDR4_BIT];
        OFS_CFG:   mode_req        <= bus_wdata[MODE_BIT];
        default: ;
      endcase
    end
  end

  assign start      = wr_ok && (bus_addr == OFS_CMD) && bus_wdata[GO_BIT];
  assign page_wen   = wr_ok && (bus_addr == OFS_PAGE);
  assign page_wdata = bus_wdata;

  always_comb begin
    rdata = '0;
    case (bus_addr)
      OFS_CMD:   rdata[GO_BIT]    = busy;
      OFS_OPC:   rdata[7:0]       = cfg.opcode;
      OFS_ADR0:  rdata[7:0]       = cfg.addr[7:0];
      OFS_ADR1:  rdata[7:0]       = cfg.addr[15:8];
      OFS_ADR2:  rdata[7:0]       = cfg.addr[23:16];
      OFS_ADR3:  rdata[7:0]       = cfg.addr[31:24];
      OFS_WBYTE: rdata[7:0]       = cfg.wbyte;
      OFS_BUS:   rdata[ADDR4_BIT] = cfg.addr4;
      OFS_CFG:   rdata[MODE_BIT]  = mode_ack;
      default: ;
    endcase
  end

  // R9: a busy cycle leaves the frame settings untouched in the next one
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg));

endmodule

// File: rtl/snor_pp_pagebuf.sv
module snor_pp_pagebuf
  import snor_pp_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int WORD_BYTES = 4,
  localparam int PAGE_WORDS = PAGE_BYTES / WORD_BYTES,
  localparam int PTR_W      = $clog2(PAGE_WORDS),
  localparam int IDX_W      = $clog2(PAGE_BYTES),
  localparam int LANE_W     = $clog2(WORD_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_req,
  input  logic                    busy,
  input  logic                    page_wen,
  input  logic [8*WORD_BYTES-1:0] page_wdata,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [7:0]              rd_byte,
  output logic                    mode_ack
);

  logic [8*WORD_BYTES-1:0] words [PAGE_WORDS];
  logic [PTR_W-1:0]        wr_ptr;

  // named events for the checks below
  logic mode_switch, enter_page, word_store;
  assign mode_switch = (mode_req != mode_ack) && !busy;
  assign enter_page  = mode_switch && mode_req;
  assign word_store  = page_wen && mode_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_ack <= 1'b0;
      wr_ptr   <= '0;
    end else begin
      if (mode_switch) mode_ack <= mode_req;
      if (enter_page)      wr_ptr <= '0;
      else if (word_store) wr_ptr <= wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (word_store) words[wr_ptr] <= page_wdata;
  end

  // little-endian lane pick: lane 0 is bits 7:0
  logic [8*WORD_BYTES-1:0] rd_word;
  assign rd_word = words[rd_idx[IDX_W-1:LANE_W]];
  assign rd_byte = rd_word[8*rd_idx[LANE_W-1:0] +: 8];

  // R6: the acknowledged mode cannot move during a frame
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_ack));
  // R7: pointer is at word 0 on the first page-mode cycle
  p_ptr_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_ack) |-> (wr_ptr == '0));
  // R8: settled direct mode leaves the pointer alone
  p_direct_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ack && !mode_req) |=> $stable(wr_ptr));

endmodule

// File: rtl/snor_pp_serializer.sv
module snor_pp_serializer
  import snor_pp_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  localparam int IDX_W  = $clog2(PAGE_BYTES),
  localparam int BIDX_W = $clog2(8 * (5 + PAGE_BYTES))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  frame_cfg_t       cfg,
  input  logic             paged,
  input  logic [7:0]       page_byte,
  output logic [IDX_W-1:0] rd_idx,
  output logic             busy,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi
);

  localparam int BPOS_W = BIDX_W - 3;

  logic              active, phase;
  logic [BIDX_W-1:0] bit_idx;
  logic [BIDX_W-1:0] last_bit;
  logic [BPOS_W-1:0] byte_pos, hdr;
  logic [BPOS_W-1:0] data_pos;
  logic [7:0]        cur_byte;
  logic              in_hdr, bit_done;

  assign last_bit = BIDX_W'(frame_bit_count(cfg.addr4, paged, PAGE_BYTES) - 1);
  assign byte_pos = bit_idx[BIDX_W-1:3];
  assign hdr      = BPOS_W'(hdr_len(cfg.addr4));
  assign in_hdr   = byte_pos < hdr;
  assign data_pos = byte_pos - hdr;
  assign rd_idx   = IDX_W'(data_pos);

  always_comb begin
    if (in_hdr)     cur_byte = hdr_byte(cfg, byte_pos[2:0]);
    else if (paged) cur_byte = page_byte;
    else            cur_byte = cfg.wbyte;
  end

  assign bit_done = active && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      phase   <= 1'b0;
      bit_idx <= '0;
    end else if (!active) begin
      if (start) begin
        active  <= 1'b1;
        phase   <= 1'b0;
        bit_idx <= '0;
      end
    end else if (!phase) begin
      phase <= 1'b1;
    end else begin
      phase <= 1'b0;
      if (bit_idx == last_bit) active  <= 1'b0;
      else                     bit_idx <= bit_idx + 1'b1;
    end
  end

  assign busy = active;
  assign cs_n = !active;
  assign sck  = bit_done;
  assign mosi = active && cur_byte[3'd7 - bit_idx[2:0]];

  // R2: an accepted go bit makes the engine busy next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R10: data is held through the high half of each bit
  p_mosi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));
  // R4: bit index never runs past the frame length
  p_bit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bit_idx <= last_bit));

endmodule

// File: rtl/snor_pp_engine.sv
module snor_pp_engine
  import snor_pp_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wen,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        flash_sck,
  output logic        flash_cs_n,
  output logic        flash_mosi
);

  frame_cfg_t       cfg;
  logic             start, busy, mode_req, mode_ack, page_wen;
  logic [31:0]      page_wdata;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       page_byte;

  snor_pp_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wen    (bus_wen),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .mode_ack   (mode_ack),
    .rdata      (bus_rdata),
    .start      (start),
    .cfg        (cfg),
    .mode_req   (mode_req),
    .page_wen   (page_wen),
    .page_wdata (page_wdata)
  );

  snor_pp_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(WORD_BYTES)) u_pagebuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_req   (mode_req),
    .busy       (busy),
    .page_wen   (page_wen),
    .page_wdata (page_wdata),
    .rd_idx     (rd_idx),
    .rd_byte    (page_byte),
    .mode_ack   (mode_ack)
  );

  snor_pp_serializer #(.PAGE_BYTES(PAGE_BYTES)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg       (cfg),
    .paged     (mode_ack),
    .page_byte (page_byte),
    .rd_idx    (rd_idx),
    .busy      (busy),
    .sck       (flash_sck),
    .cs_n      (flash_cs_n),
    .mosi      (flash_mosi)
  );

  // R10: no clock pulse outside a selected frame
  p_sck_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> !flash_sck);

endmodule

// File: tb/snor_pp_engine_tb_top.sv
module snor_pp_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        flash_sck, flash_cs_n, flash_mosi;

  always #10 clk = ~clk;

  snor_pp_engine dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_sck(flash_sck),
    .flash_cs_n(flash_cs_n), .flash_mosi(flash_mosi));

  int checks = 0;
  int errors = 0;

  // behavioural model of the register bank and page
  logic [7:0]  m_opc = 0, m_wbyte = 0;
  logic [31:0] m_addr = 0;
  logic        m_addr4 = 0, m_mode = 0, m_busy = 0;
  int          m_ptr = 0;
  logic [7:0]  page_model [128];
  logic [7:0]  exp_q [$];
  logic        cap_bits [$];
  int          frames_seen = 0;
  int          frames_target = 0;
  logic        prev_cs = 1'b1, prev_mosi = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic build_expected();
    int na;
    exp_q.delete();
    exp_q.push_back(m_opc);
    na = m_addr4 ? 4 : 3;
    for (int i = na - 1; i >= 0; i--) exp_q.push_back(m_addr[8*i +: 8]);
    if (m_mode) for (int j = 0; j < 128; j++) exp_q.push_back(page_model[j]);
    else exp_q.push_back(m_wbyte);
  endtask

  task automatic model_update(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h020: m_opc = d[7:0];
      12'h010: m_addr[7:0] = d[7:0];
      12'h014: m_addr[15:8] = d[7:0];
      12'h018: m_addr[23:16] = d[7:0];
      12'h0c8: m_addr[31:24] = d[7:0];
      12'h01c: m_wbyte = d[7:0];
      12'h0cc: m_addr4 = d[4];
      12'h064: begin
        if (d[0] && !m_mode) m_ptr = 0;
        m_mode = d[0];
      end
      12'h098: if (m_mode) begin
        for (int k = 0; k < 4; k++) page_model[m_ptr*4 + k] = d[8*k +: 8];
        m_ptr = (m_ptr + 1) % 32;
      end
      12'h000: if (d[4]) begin
        m_busy = 1'b1;
        build_expected();
        cap_bits.delete();
        frames_target = frames_seen + 1;
      end
      default: ;
    endcase
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    if (!m_busy) model_update(a, d);
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_frame(input string tag);
    logic [7:0] b;
    wait (frames_seen == frames_target);
    m_busy = 1'b0;
    chk({tag, " bit count"}, cap_bits.size(), exp_q.size() * 8);
    for (int i = 0; i < exp_q.size() && (i * 8 + 7) < cap_bits.size(); i++) begin
      for (int k = 0; k < 8; k++) b[7-k] = cap_bits[i*8 + k];
      chk($sformatf("%s byte %0d", tag, i), {24'b0, b}, {24'b0, exp_q[i]});
    end
  endtask

  // per-clock protocol monitor and frame capture (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (flash_cs_n && flash_sck) begin
        errors++;
        $display("FAIL R10 sck high with cs_n high actual=1 expected=0");
      end
      if (flash_sck) begin
        checks++;
        if (flash_mosi !== prev_mosi) begin
          errors++;
          $display("FAIL R10 mosi moved at sck rise actual=%b expected=%b", flash_mosi, prev_mosi);
        end
        cap_bits.push_back(flash_mosi);
      end
      if (!prev_cs && flash_cs_n) frames_seen++;
      prev_cs   = flash_cs_n;
      prev_mosi = flash_mosi;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 128; i++) page_model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", {31'b0, flash_cs_n}, 32'h1);
    chk("R1 sck", {31'b0, flash_sck}, 32'h0);
    rd(12'h000, v); chk("R1 cmd", v, 32'h0);
    rd(12'h064, v); chk("R1 cfg", v, 32'h0);

    // R3 R4 direct, 3-byte address
    wr(12'h020, 32'h02); wr(12'h010, 32'h56); wr(12'h014, 32'h34);
    wr(12'h018, 32'h12); wr(12'h01c, 32'hA5); wr(12'h0cc, 32'h0);
    wr(12'h000, 32'h10);
    rd(12'h000, v); chk("R2 busy during frame", v, 32'h10);
    finish_frame("R3 R4 direct 3B");
    rd(12'h000, v); chk("R2 go cleared", v, 32'h0);

    // R3 R4 direct, 4-byte address; R9 writes ignored while busy
    wr(12'h020, 32'h12); wr(12'h0c8, 32'h9A); wr(12'h0cc, 32'h10);
    wr(12'h01c, 32'h3C); wr(12'h010, 32'hE1);
    wr(12'h000, 32'h10);
    wr(12'h01c, 32'h77); wr(12'h000, 32'h10); wr(12'h064, 32'h1);
    finish_frame("R3 R4 direct 4B");
    rd(12'h01c, v); chk("R9 data byte kept", v, 32'h3C);
    rd(12'h064, v); chk("R9 mode kept", v, 32'h0);
    repeat (10) @(negedge clk);
    chk("R9 no second frame", frames_seen, frames_target);

    // R6 handshake into page mode
    wr(12'h064, 32'h1);
    rd(12'h064, v); chk("R6 readback lags", v, 32'h0);
    @(negedge clk);
    rd(12'h064, v); chk("R6 readback switched", v, 32'h1);

    // R5 R7 page fill with wrap on the 33rd word
    for (int k = 0; k < 33; k++) wr(12'h098, 32'h03020100 + k * 32'h04040404 + 32'h1000_0000 * (k / 32));
    wr(12'h020, 32'h32);
    wr(12'h000, 32'h10);
    wr(12'h064, 32'h0);
    finish_frame("R5 R7 page wrap");
    rd(12'h064, v); chk("R6 R9 mode not changed while busy", v, 32'h1);

    // R8 direct-mode page writes ignored; R7 rewind on re-entry
    wr(12'h064, 32'h0);
    @(negedge clk);
    rd(12'h064, v); chk("R6 back to direct", v, 32'h0);
    for (int k = 0; k < 4; k++) wr(12'h098, 32'hDEADBEEF);
    wr(12'h064, 32'h1);
    @(negedge clk);
    wr(12'h098, 32'hCAFEF00D); wr(12'h098, 32'h89ABCDEF);
    wr(12'h0cc, 32'h0);
    wr(12'h000, 32'h10);
    finish_frame("R7 R8 rewind and ignore");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule